// File: doc/BRIEF.md
# Context-Banked Carry/Zero Flag Store

This block holds the carry and zero condition flags of a small processor core, kept in three independent banks. One bank belongs to ordinary program execution, one to maskable interrupt service and one to non-maskable interrupt service. The block follows the current execution context from entry and return strobes, and it exposes the flag pair of that context. Flags are never copied or saved when the context changes. Each bank keeps its last value until code that runs in its own context writes it again.

The core's execution unit sends an ALU result, a carry/borrow bit and a bit-test value, together with one of three update strobes. An arithmetic update writes both flags. A logic update writes only zero. A bit-test update writes only carry. Interrupt-entry strobes switch to the matching bank and record the context that was left in a short history. A return strobe takes the most recent entry back out of that history. After reset the block is in the non-maskable context, so the first return leads into ordinary execution.

Top module: `flag_bank`

## Requirements
- R1: While reset is held and directly after it, `ctx_o` reads 2 (non-maskable context), the history is empty, and the carry and zero flags of all three banks are 0. Context encoding: 0 = normal, 1 = maskable interrupt, 2 = non-maskable interrupt. The value 3 never appears.
- R2: `nmi_enter_i` makes `ctx_o` equal 2 from the next cycle and pushes the previous context into the history. It takes priority over `irq_enter_i` and `ret_i` in the same cycle.
- R3: `irq_enter_i` without `nmi_enter_i` makes `ctx_o` equal 1 from the next cycle and pushes the previous context. It takes priority over `ret_i`.
- R4: `ret_i` with no entry strobe, while the history is not empty, makes the most recently pushed context active again from the next cycle and removes it from the history.
- R5: `ret_i` with an empty history, which includes every return made in normal context, leaves or puts the block in normal context (0).
- R6: The history holds HIST_DEPTH entries (2 by default). A push into a full history discards the oldest entry.
- R7: `upd_arith_i` loads the active bank's carry with `alu_carry_i` and its zero with 1 exactly when `alu_res_i` is all zeros. The new values appear on the outputs in the next cycle.
- R8: `upd_logic_i` loads only the active bank's zero flag from the result. Its carry is left unchanged.
- R9: `upd_bit_i` loads only the active bank's carry with `bit_val_i`. Its zero is left unchanged.
- R10: Only the bank of the context that is active during the update cycle is written. The other banks keep their values across any number of context changes. This also holds when an update and a context change fall in the same cycle.
- R11: When several update strobes are asserted together, arithmetic takes priority over logic, and logic takes priority over bit-test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| nmi_enter_i | input | 1 | Entry into non-maskable interrupt service |
| irq_enter_i | input | 1 | Entry into maskable interrupt service |
| ret_i | input | 1 | Return from interrupt |
| upd_arith_i | input | 1 | Arithmetic flag update (carry and zero) |
| upd_logic_i | input | 1 | Logic flag update (zero only) |
| upd_bit_i | input | 1 | Bit-test flag update (carry only) |
| alu_res_i | input | DATA_W | ALU result used for zero detection |
| alu_carry_i | input | 1 | Carry or borrow out of the ALU |
| bit_val_i | input | 1 | Value of the tested bit |
| carry_o | output | 1 | Carry flag of the active bank |
| zero_o | output | 1 | Zero flag of the active bank |
| ctx_o | output | 2 | Active context (0 normal, 1 interrupt, 2 NMI) |

## Verification
Some rules are checked by the assertions on every cycle:
- Each entry strobe leads to the right context, and the priority between the strobes is kept.
- A return with an empty history lands in normal context, and a return with a non-empty history restores the stored context.
- The history count never passes its depth.
- A bank that is not selected holds its flags.
- Each update kind writes exactly the flags it owns.

Other behaviour only the bench scenarios can show, because it spans many cycles. This covers nested entries and returns that expose values written long before, the loss of the oldest context after an overflow, and full sweeps of the result value through the zero detector in each bank.

// File: rtl/flag_bank_pkg.sv
package flag_bank_pkg;

   typedef enum logic [1:0] {
      CTX_NORMAL = 2'd0,
      CTX_IRQ    = 2'd1,
      CTX_NMI    = 2'd2
   } ctx_e;

   localparam int NUM_CTX = 3;

   typedef struct packed {
      logic carry;
      logic zero;
   } flag_pair_t;

endpackage

// File: rtl/fb_ctx_tracker.sv
module fb_ctx_tracker
   import flag_bank_pkg::*;
#(
   parameter int HIST_DEPTH = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic nmi_enter,
   input  logic irq_enter,
   input  logic ret,
   output ctx_e ctx_o
);

   localparam int CNT_W = $clog2(HIST_DEPTH + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(HIST_DEPTH);

   ctx_e             cur_q;
   logic [CNT_W-1:0] cnt_q;
   logic             do_push;
   logic             do_pop;
   ctx_e             top_ent;

   assign do_push = nmi_enter | irq_enter;
   assign do_pop  = ret & ~do_push;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q <= CTX_NMI;
      end else if (nmi_enter) begin
         cur_q <= CTX_NMI;
      end else if (irq_enter) begin
         cur_q <= CTX_IRQ;
      end else if (do_pop) begin
         cur_q <= (cnt_q != '0) ? top_ent : CTX_NORMAL;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (do_push) begin
         if (cnt_q != CNT_FULL) cnt_q <= cnt_q + 1'b1;
      end else if (do_pop) begin
         if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      end
   end

   for (genvar i = 0; i < HIST_DEPTH; i++) begin : g_hist
      ctx_e ent_q;
      ctx_e push_src;
      ctx_e pop_src;

      if (i == 0) begin : g_head
         assign push_src = cur_q;
      end else begin : g_body
         assign push_src = g_hist[i-1].ent_q;
      end

      if (i == HIST_DEPTH - 1) begin : g_tail
         assign pop_src = CTX_NORMAL;
      end else begin : g_link
         assign pop_src = g_hist[i+1].ent_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent_q <= CTX_NORMAL;
         end else if (do_push) begin
            ent_q <= push_src;
         end else if (do_pop) begin
            ent_q <= pop_src;
         end
      end
   end

   assign top_ent = g_hist[0].ent_q;
   assign ctx_o   = cur_q;

   // R2
   nmi_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_enter |=> ctx_o == CTX_NMI);

   // R3
   irq_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_enter && !nmi_enter) |=> ctx_o == CTX_IRQ);

   // R4
   ret_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (do_pop && cnt_q != '0) |=> ctx_o == $past(top_ent));

   // R5
   ret_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (do_pop && cnt_q == '0) |=> ctx_o == CTX_NORMAL);

   // R6
   depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_FULL);

   // R1
   ctx_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctx_o != 2'd3);

endmodule

// File: rtl/fb_flag_pair.sv
module fb_flag_pair
   import flag_bank_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sel,
   input  logic       upd_arith,
   input  logic       upd_logic,
   input  logic       upd_bit,
   input  logic       res_zero,
   input  logic       alu_carry,
   input  logic       bit_val,
   output flag_pair_t flags_o
);

   flag_pair_t pair_q;
   flag_pair_t pair_d;

   always_comb begin
      pair_d = pair_q;
      if (sel) begin
         if (upd_arith) begin
            pair_d.carry = alu_carry;
            pair_d.zero  = res_zero;
         end else if (upd_logic) begin
            pair_d.zero  = res_zero;
         end else if (upd_bit) begin
            pair_d.carry = bit_val;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pair_q <= '0;
      else        pair_q <= pair_d;
   end

   assign flags_o = pair_q;

   // R10
   idle_pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |=> $stable(flags_o));

   // R8
   logic_keeps_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && upd_logic && !upd_arith) |=> $stable(flags_o.carry));

   // R9
   bit_loads_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && upd_bit && !upd_arith && !upd_logic)
         |=> (flags_o.carry == $past(bit_val)) && $stable(flags_o.zero));

endmodule

// File: rtl/flag_bank.sv
module flag_bank
   import flag_bank_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int HIST_DEPTH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              nmi_enter_i,
   input  logic              irq_enter_i,
   input  logic              ret_i,
   input  logic              upd_arith_i,
   input  logic              upd_logic_i,
   input  logic              upd_bit_i,
   input  logic [DATA_W-1:0] alu_res_i,
   input  logic              alu_carry_i,
   input  logic              bit_val_i,
   output logic              carry_o,
   output logic              zero_o,
   output logic [1:0]        ctx_o
);

   if (DATA_W < 1) begin : g_bad_width
      $error("flag_bank: DATA_W must be at least 1");
   end
   if (HIST_DEPTH < 1) begin : g_bad_depth
      $error("flag_bank: HIST_DEPTH must be at least 1");
   end

   ctx_e       ctx;
   logic       res_zero;
   flag_pair_t bank [NUM_CTX];
   flag_pair_t act;

   fb_ctx_tracker #(
      .HIST_DEPTH (HIST_DEPTH)
   ) i_tracker (
      .clk       (clk),
      .rst_n     (rst_n),
      .nmi_enter (nmi_enter_i),
      .irq_enter (irq_enter_i),
      .ret       (ret_i),
      .ctx_o     (ctx)
   );

   assign res_zero = (alu_res_i == '0);

   for (genvar p = 0; p < NUM_CTX; p++) begin : g_pair
      fb_flag_pair i_pair (
         .clk       (clk),
         .rst_n     (rst_n),
         .sel       (ctx == ctx_e'(p)),
         .upd_arith (upd_arith_i),
         .upd_logic (upd_logic_i),
         .upd_bit   (upd_bit_i),
         .res_zero  (res_zero),
         .alu_carry (alu_carry_i),
         .bit_val   (bit_val_i),
         .flags_o   (bank[p])
      );
   end

   always_comb begin
      unique case (ctx)
         CTX_IRQ: act = bank[1];
         CTX_NMI: act = bank[2];
         default: act = bank[0];
      endcase
   end

   assign carry_o = act.carry;
   assign zero_o  = act.zero;
   assign ctx_o   = ctx;

   // R7
   arith_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_arith_i && !nmi_enter_i && !irq_enter_i && !ret_i)
         |=> (carry_o == $past(alu_carry_i)) && (zero_o == ($past(alu_res_i) == '0)));

   // R10
   hold_without_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd_arith_i && !upd_logic_i && !upd_bit_i && !nmi_enter_i && !irq_enter_i && !ret_i)
         |=> $stable({carry_o, zero_o, ctx_o}));

endmodule

// File: tb/test_flag_bank.sv
module test_flag_bank;

   localparam int  DATA_W = 8;
   localparam time CLK_P  = 4ns;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              nmi_enter_i, irq_enter_i, ret_i;
   logic              upd_arith_i, upd_logic_i, upd_bit_i;
   logic [DATA_W-1:0] alu_res_i;
   logic              alu_carry_i, bit_val_i;
   logic              carry_o, zero_o;
   logic [1:0]        ctx_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   int mctx;
   int mstk0, mstk1, mcnt;
   bit mc [3];
   bit mz [3];

   always #(CLK_P/2) clk = ~clk;

   flag_bank #(.DATA_W(DATA_W), .HIST_DEPTH(2)) i_flag_bank (
      .clk(clk), .rst_n(rst_n),
      .nmi_enter_i(nmi_enter_i), .irq_enter_i(irq_enter_i), .ret_i(ret_i),
      .upd_arith_i(upd_arith_i), .upd_logic_i(upd_logic_i), .upd_bit_i(upd_bit_i),
      .alu_res_i(alu_res_i), .alu_carry_i(alu_carry_i), .bit_val_i(bit_val_i),
      .carry_o(carry_o), .zero_o(zero_o), .ctx_o(ctx_o)
   );

   task automatic check(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   task automatic push_model(int old);
      mstk1 = mstk0;
      mstk0 = old;
      if (mcnt < 2) mcnt++;
   endtask

   task automatic step(bit n, bit q, bit r, bit ua, bit ul, bit ub,
                       int res, bit cy, bit bv, string tag);
      int old;
      @(negedge clk);
      nmi_enter_i = n;  irq_enter_i = q;  ret_i = r;
      upd_arith_i = ua; upd_logic_i = ul; upd_bit_i = ub;
      alu_res_i = res[DATA_W-1:0]; alu_carry_i = cy; bit_val_i = bv;
      @(posedge clk);
      #1;
      if (ua) begin
         mc[mctx] = cy;
         mz[mctx] = (res[DATA_W-1:0] == 0);
      end else if (ul) begin
         mz[mctx] = (res[DATA_W-1:0] == 0);
      end else if (ub) begin
         mc[mctx] = bv;
      end
      old = mctx;
      if (n) begin
         push_model(old); mctx = 2;
      end else if (q) begin
         push_model(old); mctx = 1;
      end else if (r) begin
         if (mcnt > 0) begin
            mctx = mstk0; mstk0 = mstk1; mstk1 = 0; mcnt--;
         end else begin
            mctx = 0;
         end
      end
      check(tag, "ctx", int'(ctx_o), mctx);
      check(tag, "carry", int'(carry_o), int'(mc[mctx]));
      check(tag, "zero", int'(zero_o), int'(mz[mctx]));
   endtask

   task automatic idle_inputs();
      @(negedge clk);
      nmi_enter_i = 0; irq_enter_i = 0; ret_i = 0;
      upd_arith_i = 0; upd_logic_i = 0; upd_bit_i = 0;
      alu_res_i = '0; alu_carry_i = 0; bit_val_i = 0;
   endtask

   initial begin
      #(CLK_P * 200000);
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      rst_n = 0;
      nmi_enter_i = 0; irq_enter_i = 0; ret_i = 0;
      upd_arith_i = 0; upd_logic_i = 0; upd_bit_i = 0;
      alu_res_i = '0; alu_carry_i = 0; bit_val_i = 0;
      mctx = 2; mstk0 = 0; mstk1 = 0; mcnt = 0;
      for (int k = 0; k < 3; k++) begin mc[k] = 0; mz[k] = 0; end
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", "ctx", int'(ctx_o), 2);
      check("R1", "carry", int'(carry_o), 0);
      check("R1", "zero", int'(zero_o), 0);
      rst_n = 1;
      idle_inputs();
      check("R1", "ctx after release", int'(ctx_o), 2);

      // R1/R7: write NMI bank, then R5: return with empty history
      step(0,0,0, 1,0,0, 8'h00, 1, 0, "R7");
      step(0,0,1, 0,0,0, 0, 0, 0, "R5");
      step(0,0,1, 0,0,0, 0, 0, 0, "R5");

      // R7: full result sweep in normal context
      for (int v = 0; v < 256; v++)
         step(0,0,0, 1,0,0, v, v[3] ^ v[5], 0, "R7");

      // R3 entry, R8 logic sweep in interrupt bank
      step(0,1,0, 0,0,0, 0, 0, 0, "R3");
      step(0,0,0, 0,0,1, 0, 0, 1, "R9");
      for (int v = 0; v < 256; v++)
         step(0,0,0, 0,1,0, v, 0, 0, "R8");

      // R2 nested entry, R9 bit sweep in NMI bank
      step(0,0,0, 1,0,0, 8'h05, 0, 0, "R7");
      step(1,0,0, 0,0,0, 0, 0, 0, "R2");
      for (int v = 0; v < 64; v++)
         step(0,0,0, 0,0,1, 0, 0, v[0] ^ v[2], "R9");

      // R4 returns restore earlier banks untouched (R10)
      step(0,0,1, 0,0,0, 0, 0, 0, "R4");
      step(0,0,1, 0,0,0, 0, 0, 0, "R4");
      step(0,0,1, 0,0,0, 0, 0, 0, "R5");

      // R11 update priority
      step(0,0,0, 1,1,1, 8'h00, 0, 1, "R11");
      step(0,0,0, 0,1,1, 8'h40, 0, 1, "R11");

      // R2 priority over irq and ret; R3 over ret
      step(1,1,1, 0,0,0, 0, 0, 0, "R2");
      step(0,1,1, 0,0,0, 0, 0, 0, "R3");

      // R10: update in same cycle as a context change writes the old bank
      step(1,0,0, 1,0,0, 8'h00, 1, 0, "R10");
      step(0,0,1, 0,0,0, 0, 0, 0, "R10");

      // R6: overflow discards oldest context
      step(0,0,1, 0,0,0, 0, 0, 0, "R4");
      step(0,0,1, 0,0,0, 0, 0, 0, "R5");
      step(1,0,0, 0,0,0, 0, 0, 0, "R2");
      step(0,1,0, 0,0,0, 0, 0, 0, "R6");
      step(1,0,0, 0,0,0, 0, 0, 0, "R6");
      step(0,1,0, 0,0,0, 0, 0, 0, "R6");
      step(0,0,1, 0,0,0, 0, 0, 0, "R6");
      step(0,0,1, 0,0,0, 0, 0, 0, "R6");
      step(0,0,1, 0,0,0, 0, 0, 0, "R6");
      check("R6", "oldest dropped ctx", int'(ctx_o), 0);

      // R10: mixed random traffic
      for (int t = 0; t < 3000; t++) begin
         int rr;
         rr = $urandom;
         step(rr[2:0] == 0, rr[5:3] == 0, rr[7:6] == 0,
              rr[8], rr[9], rr[10], rr[18:11] & {8{rr[19]}}, rr[20], rr[21], "R10");
      end

      idle_inputs();
      finish_run();
   end

endmodule